// File: doc/BRIEF.md
# Video Splitter Port Enable Controller

This block decides which of four downstream video output ports is driven, whether the upstream input termination is switched on, whether the analog path sits in standby, and what level the upstream hot-plug line carries. The ports can be chosen in two ways. In pin mode, a broadcast pin and a two-bit port number come from strap pins. In register mode, the choice comes from per-port enable bits held in a register file.

Each sink hot-plug input passes through a two-flop synchronizer. The input then gates its port and feeds a hot-plug summary whose polarity can be inverted. Three further conditions remove every port: standby, a squelch condition (no input clock activity while squelch is allowed), and a low output-enable pin. The clock-activity flag comes from a detector that already runs in this clock domain. The reset is assumed to be released synchronously before it reaches the block. All outputs are registered, so they change only on a clock edge.

Top module: `spl_port_ctl`

## Requirements
- R1: While `oe_i` is low, the next clock edge sets `port_en_o` to 0, `hpd_src_o` to 0, `term_en_o` to 0 and `standby_o` to 1. This holds for every value of the other inputs.
- R2: With `oe_i` high, `reg_mode_i` low and `bcast_i` high, all four ports are selected. The hot-plug summary is the OR of the four synchronized sink inputs.
- R3: With `oe_i` high, `reg_mode_i` low and `bcast_i` low, exactly one port is selected: `psel_i` value 0, 1, 2, 3 selects port 1, 2, 3, 4, which is bit 0, 1, 2, 3 of `port_en_o`. The hot-plug summary is that port's synchronized sink input alone. `cfg_port_en_i` has no effect in this mode.
- R4: With `oe_i` high and `reg_mode_i` high, the selected ports are the bits of `cfg_port_en_i` (bit 0 = port 1). The hot-plug summary is the OR over the ports of (sink AND enable bit). `bcast_i` and `psel_i` have no effect in this mode.
- R5: With `cfg_det_en_i` high, a selected port whose synchronized sink input is low is not enabled. With `cfg_det_en_i` low, the sink inputs do not gate the ports.
- R6: `term_en_o` is 1 exactly when `oe_i` and `cfg_run_i` are both high, unless `cfg_det_en_i` is high and all four synchronized sink inputs are low.
- R7: With `cfg_run_i` low, `standby_o` is 1 and all port enables are 0. The hot-plug output is not affected.
- R8: With `cfg_sq_dis_i` low and `clk_act_i` low, all port enables are 0. They return when `clk_act_i` goes high again. With `cfg_sq_dis_i` high, `clk_act_i` has no effect.
- R9: While `oe_i` is high, `hpd_src_o` equals the hot-plug summary XOR `cfg_hpd_inv_i`.
- R10: A change on a pin, a configuration bit or `clk_act_i` reaches the outputs at the first clock edge. A change on `hpd_sink_i` reaches the outputs at the third clock edge.
- R11: In reset, `port_en_o` is 0, `term_en_o` is 0, `standby_o` is 1 and `hpd_src_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oe_i | input | 1 | Output enable pin |
| reg_mode_i | input | 1 | 1 = register control, 0 = pin control |
| bcast_i | input | 1 | Pin mode: drive all ports |
| psel_i | input | 2 | Pin mode: port number (0 = port 1) |
| hpd_sink_i | input | 4 | Asynchronous sink hot-plug inputs, bit 0 = port 1 |
| clk_act_i | input | 1 | Input clock activity flag, synchronous |
| cfg_run_i | input | 1 | 1 = normal operation, 0 = standby |
| cfg_port_en_i | input | 4 | Register-mode port enables, bit 0 = port 1 |
| cfg_det_en_i | input | 1 | Connection detector enable |
| cfg_sq_dis_i | input | 1 | 1 = squelch disabled |
| cfg_hpd_inv_i | input | 1 | 1 = inverted hot-plug output |
| port_en_o | output | 4 | Registered port enables, bit 0 = port 1 |
| term_en_o | output | 1 | Input termination enable |
| standby_o | output | 1 | Analog standby request |
| hpd_src_o | output | 1 | Upstream hot-plug output |

## Verification
The hardest case to reach is the interplay between the hot-plug delay and register-clocked control. A sink input change lands two edges later than a pin change. Sampling too early therefore shows a mix of old hot-plug state and new selection. The bench holds each combination of sink pattern, mode, polarity and detector setting long enough for the synchronizer to settle before comparing. A separate sequence then changes a port number and a sink input in isolation and samples at each edge, confirming the one-edge and three-edge latencies.

// File: rtl/spl_pkg.sv
package spl_pkg;

  // How the candidate port set is chosen this cycle.
  typedef enum logic [1:0] {
    ROUTE_OFF = 2'd0,
    ROUTE_ALL = 2'd1,
    ROUTE_ONE = 2'd2,
    ROUTE_REG = 2'd3
  } route_e;

endpackage

// File: rtl/spl_hpd_sync.sv
module spl_hpd_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o
);

  logic [N-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [N-1:0] stg_d;
    if (s == 0) begin : g_first
      assign stg_d = async_i;
    end else begin : g_rest
      assign stg_d = stg_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '0;
      else        stg_q[s] <= stg_d;
    end
  end

  assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/spl_route_sel.sv
module spl_route_sel
  import spl_pkg::*;
#(
  parameter int N     = 4,
  parameter int SEL_W = 2
) (
  input  logic             oe_i,
  input  logic             reg_mode_i,
  input  logic             bcast_i,
  input  logic [SEL_W-1:0] psel_i,
  input  logic [N-1:0]     cfg_port_en_i,
  input  logic [N-1:0]     hpd_s_i,
  output logic [N-1:0]     mask_o,
  output logic             hpd_sum_o
);

  route_e       route;
  logic [N-1:0] one_hot;

  for (genvar gp = 0; gp < N; gp++) begin : g_dec
    assign one_hot[gp] = (psel_i == SEL_W'(gp));
  end

  always_comb begin
    if (!oe_i)          route = ROUTE_OFF;
    else if (reg_mode_i) route = ROUTE_REG;
    else if (bcast_i)   route = ROUTE_ALL;
    else                route = ROUTE_ONE;
  end

  always_comb begin
    unique case (route)
      ROUTE_ALL: mask_o = '1;
      ROUTE_ONE: mask_o = one_hot;
      ROUTE_REG: mask_o = cfg_port_en_i;
      default:   mask_o = '0;
    endcase
  end

  // Hot-plug summary: sink state of every selected port, ORed.
  assign hpd_sum_o = |(hpd_s_i & mask_o);

endmodule

// File: rtl/spl_gate.sv
module spl_gate #(
  parameter int N = 4
) (
  input  logic         oe_i,
  input  logic         cfg_run_i,
  input  logic         cfg_det_en_i,
  input  logic         cfg_sq_dis_i,
  input  logic         clk_act_i,
  input  logic         cfg_hpd_inv_i,
  input  logic [N-1:0] mask_i,
  input  logic [N-1:0] hpd_s_i,
  input  logic         hpd_sum_i,
  output logic [N-1:0] port_d_o,
  output logic         term_d_o,
  output logic         stby_d_o,
  output logic         hpd_d_o
);

  logic         awake;
  logic         squelched;
  logic         live;
  logic [N-1:0] connected;
  logic         none_attached;

  assign awake         = oe_i & cfg_run_i;
  assign squelched     = ~cfg_sq_dis_i & ~clk_act_i;
  assign live          = awake & ~squelched;
  assign connected     = cfg_det_en_i ? hpd_s_i : '1;
  assign none_attached = cfg_det_en_i & ~(|hpd_s_i);

  always_comb begin
    port_d_o = live ? (mask_i & connected) : '0;
    term_d_o = awake & ~none_attached;
    stby_d_o = ~awake;
    hpd_d_o  = oe_i & (hpd_sum_i ^ cfg_hpd_inv_i);
  end

endmodule

// File: rtl/spl_port_ctl.sv
module spl_port_ctl #(
  parameter int NPORT       = 4,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             oe_i,
  input  logic             reg_mode_i,
  input  logic             bcast_i,
  input  logic [SEL_W-1:0] psel_i,
  input  logic [NPORT-1:0] hpd_sink_i,
  input  logic             clk_act_i,
  input  logic             cfg_run_i,
  input  logic [NPORT-1:0] cfg_port_en_i,
  input  logic             cfg_det_en_i,
  input  logic             cfg_sq_dis_i,
  input  logic             cfg_hpd_inv_i,
  output logic [NPORT-1:0] port_en_o,
  output logic             term_en_o,
  output logic             standby_o,
  output logic             hpd_src_o
);

  logic [NPORT-1:0] hpd_s;
  logic [NPORT-1:0] mask;
  logic             hpd_sum;
  logic [NPORT-1:0] port_d, port_q;
  logic             term_d, term_q;
  logic             stby_d, stby_q;
  logic             hpd_d, hpd_q;
  logic             upd;

  spl_hpd_sync #(.N(NPORT), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (hpd_sink_i),
    .sync_o  (hpd_s)
  );

  spl_route_sel #(.N(NPORT), .SEL_W(SEL_W)) u_route (
    .oe_i          (oe_i),
    .reg_mode_i    (reg_mode_i),
    .bcast_i       (bcast_i),
    .psel_i        (psel_i),
    .cfg_port_en_i (cfg_port_en_i),
    .hpd_s_i       (hpd_s),
    .mask_o        (mask),
    .hpd_sum_o     (hpd_sum)
  );

  spl_gate #(.N(NPORT)) u_gate (
    .oe_i          (oe_i),
    .cfg_run_i     (cfg_run_i),
    .cfg_det_en_i  (cfg_det_en_i),
    .cfg_sq_dis_i  (cfg_sq_dis_i),
    .clk_act_i     (clk_act_i),
    .cfg_hpd_inv_i (cfg_hpd_inv_i),
    .mask_i        (mask),
    .hpd_s_i       (hpd_s),
    .hpd_sum_i     (hpd_sum),
    .port_d_o      (port_d),
    .term_d_o      (term_d),
    .stby_d_o      (stby_d),
    .hpd_d_o       (hpd_d)
  );

  // Clock enable: registers load only when some next value differs.
  always_comb begin
    upd = (port_d != port_q) | (term_d != term_q) |
          (stby_d != stby_q) | (hpd_d != hpd_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_q <= '0;
      term_q <= 1'b0;
      stby_q <= 1'b1;
      hpd_q  <= 1'b0;
    end else if (upd) begin
      port_q <= port_d;
      term_q <= term_d;
      stby_q <= stby_d;
      hpd_q  <= hpd_d;
    end
  end

  assign port_en_o = port_q;
  assign term_en_o = term_q;
  assign standby_o = stby_q;
  assign hpd_src_o = hpd_q;

  // ---------------- assertions ----------------
  assert_oe_low_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!oe_i) |-> (port_en_o == '0 && !hpd_src_o && !term_en_o && standby_o));

  assert_single_port_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(oe_i && !reg_mode_i && !bcast_i) |-> $onehot0(port_en_o));

  assert_reg_subset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_mode_i) |-> ((port_en_o & ~$past(cfg_port_en_i)) == '0));

  assert_detect_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_det_en_i) |-> ((port_en_o & ~$past(hpd_s)) == '0));

  assert_term_needs_awake_R6: assert property (@(posedge clk) disable iff (!rst_n)
    term_en_o |-> $past(oe_i && cfg_run_i));

  assert_standby_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cfg_run_i) |-> (standby_o && port_en_o == '0));

  assert_squelch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cfg_sq_dis_i && !clk_act_i) |-> (port_en_o == '0));

endmodule

// File: tb/sim_spl_port_ctl.sv
module sim_spl_port_ctl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       oe, reg_mode, bcast, clk_act, run, det, sqdis, inv;
  logic [1:0] psel;
  logic [3:0] hpd, cfg_en;
  logic [3:0] port_en;
  logic       term_en, standby, hpd_src;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  spl_port_ctl u0 (
    .clk (clk), .rst_n (rst_n), .oe_i (oe), .reg_mode_i (reg_mode),
    .bcast_i (bcast), .psel_i (psel), .hpd_sink_i (hpd), .clk_act_i (clk_act),
    .cfg_run_i (run), .cfg_port_en_i (cfg_en), .cfg_det_en_i (det),
    .cfg_sq_dis_i (sqdis), .cfg_hpd_inv_i (inv),
    .port_en_o (port_en), .term_en_o (term_en), .standby_o (standby),
    .hpd_src_o (hpd_src)
  );

  task automatic chk(input string tag, input string what,
                     input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  // Expected settled outputs, written straight from the requirements.
  task automatic expect_all(input string tag);
    logic [3:0] sel, gate, pe;
    logic       sum, te, sb, hs;
    if (!oe) begin
      sel = 4'h0; sum = 1'b0;
    end else if (reg_mode) begin
      sel = cfg_en;
      sum = (hpd[0] & cfg_en[0]) | (hpd[1] & cfg_en[1]) |
            (hpd[2] & cfg_en[2]) | (hpd[3] & cfg_en[3]);
    end else if (bcast) begin
      sel = 4'hF; sum = hpd[0] | hpd[1] | hpd[2] | hpd[3];
    end else begin
      sel = 4'(1 << psel); sum = hpd[psel];
    end
    gate = det ? hpd : 4'hF;
    pe = (oe && run && (sqdis || clk_act)) ? (sel & gate) : 4'h0;
    te = oe && run && !(det && hpd == 4'h0);
    sb = !(oe && run);
    hs = oe ? (sum ^ inv) : 1'b0;
    chk(tag, "port_en", port_en, pe);
    chk(tag, "term_en", {3'b0, term_en}, {3'b0, te});
    chk(tag, "standby", {3'b0, standby}, {3'b0, sb});
    chk(tag, "hpd_src", {3'b0, hpd_src}, {3'b0, hs});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    oe = 1; reg_mode = 0; bcast = 1; psel = 0; hpd = 4'hF; cfg_en = 4'hF;
    clk_act = 1; run = 1; det = 1; sqdis = 0; inv = 0;
    repeat (4) @(negedge clk);
    // R11: reset state holds even with every input asking for activity
    chk("R11", "port_en", port_en, 4'h0);
    chk("R11", "term_en", {3'b0, term_en}, 4'h0);
    chk("R11", "standby", {3'b0, standby}, 4'h1);
    chk("R11", "hpd_src", {3'b0, hpd_src}, 4'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    expect_all("R2");

    // Main sweep: R1 R2 R3 R4 R5 R6 R9 over modes, sinks, polarity, detector
    for (int o = 0; o < 2; o++)
      for (int iv = 0; iv < 2; iv++)
        for (int d = 0; d < 2; d++)
          for (int c = 0; c < 9; c++)
            for (int h = 0; h < 16; h++) begin
              oe = 1'(o); inv = 1'(iv); det = 1'(d); hpd = 4'(h);
              if (c < 4) begin
                reg_mode = 0; bcast = 0; psel = 2'(c); cfg_en = 4'hA;
              end else if (c == 4) begin
                reg_mode = 0; bcast = 1; psel = 2'(h); cfg_en = 4'h5;
              end else begin
                reg_mode = 1; bcast = 1'(h); psel = 2'(c);
                case (c)
                  5: cfg_en = 4'h0;
                  6: cfg_en = 4'hF;
                  7: cfg_en = 4'h6;
                  default: cfg_en = 4'h9;
                endcase
              end
              repeat (4) @(negedge clk);
              if (!oe)            expect_all("R1");
              else if (reg_mode)  expect_all("R4");
              else if (bcast)     expect_all("R2");
              else                expect_all("R3");
            end

    // R7 R8 R6 sweep: standby, squelch and clock activity
    reg_mode = 0; bcast = 1; oe = 1; inv = 0;
    for (int r = 0; r < 2; r++)
      for (int s = 0; s < 2; s++)
        for (int a = 0; a < 2; a++)
          for (int d = 0; d < 2; d++)
            for (int k = 0; k < 3; k++) begin
              run = 1'(r); sqdis = 1'(s); clk_act = 1'(a); det = 1'(d);
              hpd = (k == 0) ? 4'h0 : ((k == 1) ? 4'h5 : 4'hF);
              repeat (4) @(negedge clk);
              if (!run) expect_all("R7");
              else      expect_all("R8");
            end

    // R8: clock activity returning restores the ports one edge later
    run = 1; sqdis = 0; det = 0; hpd = 4'hF; clk_act = 0;
    repeat (4) @(negedge clk);
    chk("R8", "squelched", port_en, 4'h0);
    clk_act = 1;
    @(negedge clk);
    chk("R8", "restored", port_en, 4'hF);

    // R10: pin change lands at the first edge
    bcast = 0; psel = 0; det = 1; hpd = 4'hF;
    repeat (4) @(negedge clk);
    chk("R10", "before select", port_en, 4'b0001);
    psel = 2'd2;
    @(negedge clk);
    chk("R10", "select edge 1", port_en, 4'b0100);
    // R10: sink change lands at the third edge
    hpd = 4'b1011;
    @(negedge clk);
    chk("R10", "sink edge 1", port_en, 4'b0100);
    @(negedge clk);
    chk("R10", "sink edge 2", port_en, 4'b0100);
    chk("R10", "sink edge 2 hpd", {3'b0, hpd_src}, 4'h1);
    @(negedge clk);
    chk("R10", "sink edge 3", port_en, 4'b0000);
    chk("R10", "sink edge 3 hpd", {3'b0, hpd_src}, 4'h0);
    // R10: config bit change lands at the first edge
    inv = 1;
    @(negedge clk);
    chk("R10", "polarity edge 1", {3'b0, hpd_src}, 4'h1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule